// File: doc/BRIEF.md
# Dual-Port Word Memory with Collision Arbitration

This block is a word-organised memory with two fully independent access ports, called left and right. Each port has its own address, enable, write strobe, output enable, two byte-lane selects, write data, read data and a read-valid flag. Both ports may read or write any location in the same clock cycle, including the same location. The block is a synchronous model of an asynchronous dual-port part. Reads are registered: the word stored before the edge appears one cycle after the request. Read data stays put between requests, and `*_rvalid` takes the place of tri-stated outputs.

When both ports are enabled on the same address, a small arbiter grants one of them and flags busy (active low) toward the other. A strap input picks the busy direction. In master mode the block drives `*_busy_n` and blocks the write of the losing port. In slave mode the arbiter's verdict is not used. `*_busy_n` stays high, and a low level on a port's `*_hold_n` input blocks that port's writes.

The arbiter is a three-state machine: `ARB_FREE` (no collision), `ARB_LEFT` (left granted, right busy) and `ARB_RIGHT` (right granted, left busy).
- Transition `take_left` (FREE to LEFT) fires on a new collision, except when the right port sat on that address in the previous cycle and the left port did not.
- Transition `take_right` (FREE to RIGHT) fires in exactly that exception.
- Transition `keep` (LEFT or RIGHT to itself) fires while the collision lasts.
- Transition `release` (LEFT or RIGHT to FREE) fires in the same cycle the addresses differ or either port is disabled.

Busy is decoded from the next state, so it applies in the cycle the collision appears.

Top module: `twinport_ram`

## Requirements
- R1: The two ports write and read distinct addresses in the same cycle without interfering. Read data for a request appears on the port's `*_rdata` after the next rising clock edge.
- R2: The low lane select covers bits [DATA_W/2-1:0] and the high lane select covers bits [DATA_W-1:DATA_W/2]. A write changes only the selected lanes. A read returns the selected lanes and zero in unselected lanes.
- R3: `*_rvalid` is high in the cycle after an enabled, output-enabled, non-write request with at least one lane selected. It is low after every other cycle, including write cycles, disabled cycles and cycles with output enable low.
- R4: In master mode, when both ports arrive on the same address in the same cycle, the left port is granted and `r_busy_n` goes low in that cycle. At no time are both busy outputs low.
- R5: In master mode, if the right port was already enabled on an address and the left port moves onto it, `l_busy_n` goes low. It stays low for as long as the collision lasts.
- R6: Busy returns high in the same cycle the two addresses differ or either port is disabled. It is never low without a collision.
- R7: In master mode, a write from a busy port leaves the memory unchanged. A read from a busy port returns the word stored before the granted port's same-cycle write.
- R8: In slave mode both `*_busy_n` outputs stay high. `*_hold_n` low blocks that port's writes but not its reads. In master mode `*_hold_n` is ignored.
- R9: In slave mode both ports write freely. Where both write the same lane of the same address in one cycle, the right port's data is stored.
- R10: During and right after reset, both `*_rvalid` outputs are low, both `*_busy_n` outputs are high and the arbiter is free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| master_mode | input | 1 | 1: drive busy and arbitrate; 0: take hold inputs |
| l_en | input | 1 | Left port enable |
| l_wr | input | 1 | Left write strobe (1 write, 0 read) |
| l_out_en | input | 1 | Left output enable for reads |
| l_hi_sel | input | 1 | Left high byte-lane select |
| l_lo_sel | input | 1 | Left low byte-lane select |
| l_addr | input | ADDR_W | Left word address |
| l_wdata | input | DATA_W | Left write data |
| l_hold_n | input | 1 | Left write inhibit in slave mode, active low |
| l_rdata | output | DATA_W | Left read data |
| l_rvalid | output | 1 | Left read data valid |
| l_busy_n | output | 1 | Left busy flag, active low |
| r_en | input | 1 | Right port enable |
| r_wr | input | 1 | Right write strobe |
| r_out_en | input | 1 | Right output enable |
| r_hi_sel | input | 1 | Right high byte-lane select |
| r_lo_sel | input | 1 | Right low byte-lane select |
| r_addr | input | ADDR_W | Right word address |
| r_wdata | input | DATA_W | Right write data |
| r_hold_n | input | 1 | Right write inhibit in slave mode, active low |
| r_rdata | output | DATA_W | Right read data |
| r_rvalid | output | 1 | Right read data valid |
| r_busy_n | output | 1 | Right busy flag, active low |

## Verification
The bench sweeps every address of a 16-word, 18-bit configuration with both ports at once, and then alternates single-lane writes with single-lane reads. A lane decode with an off-by-one midpoint, or one that does not zero the unselected lane, shows up as wrong words. The collision cases target the arbiter itself. Simultaneous arrival must favour left, and a late left arrival must lose to a settled right; a design that always favoured one side or ignored arrival order would flag the wrong port. Blocked writes must leave the stored word intact and a busy read must return the old word, which catches designs that merely raise the flag or read after writing. In slave mode the bench checks that busy stays high, that hold blocks writes and not reads, and that the right port wins a same-lane write tie.

// File: rtl/twinport_pkg.sv
package twinport_pkg;

    typedef enum logic [1:0] {
        ARB_FREE  = 2'd0,
        ARB_LEFT  = 2'd1,
        ARB_RIGHT = 2'd2
    } arb_state_e;

    localparam int PORTS = 2;
    localparam int LEFT  = 0;
    localparam int RIGHT = 1;

endpackage

// File: rtl/twinport_arbiter.sv
module twinport_arbiter
    import twinport_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [PORTS-1:0]               en,
    input  logic [PORTS-1:0][ADDR_W-1:0]   addr,
    output logic [PORTS-1:0]               lose
);

    arb_state_e                      state_q;
    arb_state_e                      state_d;
    logic [PORTS-1:0]                en_q;
    logic [PORTS-1:0][ADDR_W-1:0]    addr_q;
    logic [PORTS-1:0]                settled;
    logic                            coll;

    // a port is settled when it sat on the same address last cycle
    for (genvar p = 0; p < PORTS; p++) begin : g_settle
        assign settled[p] = en[p] && en_q[p] && (addr[p] == addr_q[p]);
    end

    assign coll = en[LEFT] && en[RIGHT] && (addr[LEFT] == addr[RIGHT]);

    // next-state: take_left / take_right / keep / release
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARB_FREE: begin
                if (!coll)
                    state_d = ARB_FREE;
                else if (settled[RIGHT] && !settled[LEFT])
                    state_d = ARB_RIGHT;
                else
                    state_d = ARB_LEFT;
            end
            ARB_LEFT, ARB_RIGHT: begin
                state_d = coll ? state_q : ARB_FREE;
            end
            default: state_d = ARB_FREE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ARB_FREE;
            en_q    <= '0;
            addr_q  <= '0;
        end else begin
            state_q <= state_d;
            en_q    <= en;
            addr_q  <= addr;
        end
    end

    // outputs: decoded from the decision for this cycle
    always_comb begin
        lose = '0;
        unique case (state_d)
            ARB_LEFT:  lose[RIGHT] = 1'b1;
            ARB_RIGHT: lose[LEFT]  = 1'b1;
            default:   lose        = '0;
        endcase
    end

endmodule

// File: rtl/twinport_gate.sv
module twinport_gate (
    input  logic       en,
    input  logic       wr,
    input  logic       out_en,
    input  logic       hi_sel,
    input  logic       lo_sel,
    input  logic       blocked,
    output logic [1:0] wr_lane,
    output logic       rd_req,
    output logic [1:0] rd_lane
);

    logic write_ok;

    assign write_ok = en && wr && !blocked;
    assign wr_lane  = write_ok ? {hi_sel, lo_sel} : 2'b00;
    assign rd_req   = en && !wr && out_en && (hi_sel || lo_sel);
    assign rd_lane  = {hi_sel, lo_sel};

endmodule

// File: rtl/twinport_array.sv
module twinport_array
    import twinport_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [PORTS-1:0][ADDR_W-1:0]   addr,
    input  logic [PORTS-1:0][DATA_W-1:0]   wdata,
    input  logic [PORTS-1:0][1:0]          wr_lane,
    input  logic [PORTS-1:0]               rd_req,
    input  logic [PORTS-1:0][1:0]          rd_lane,
    output logic [PORTS-1:0][DATA_W-1:0]   rdata,
    output logic [PORTS-1:0]               rvalid
);

    localparam int DEPTH = 1 << ADDR_W;
    localparam int HALF  = DATA_W / 2;

    logic [DATA_W-1:0] mem [DEPTH];

    // the higher-numbered port is applied last, so right wins a lane tie
    always_ff @(posedge clk) begin
        for (int p = 0; p < PORTS; p++) begin
            if (wr_lane[p][0])
                mem[addr[p]][HALF-1:0] <= wdata[p][HALF-1:0];
            if (wr_lane[p][1])
                mem[addr[p]][DATA_W-1:HALF] <= wdata[p][DATA_W-1:HALF];
        end
    end

    for (genvar p = 0; p < PORTS; p++) begin : g_read
        logic [DATA_W-1:0] word;
        assign word = mem[addr[p]];

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rvalid[p] <= 1'b0;
                rdata[p]  <= '0;
            end else begin
                rvalid[p] <= rd_req[p];
                if (rd_req[p]) begin
                    rdata[p][HALF-1:0]      <= rd_lane[p][0] ? word[HALF-1:0]      : '0;
                    rdata[p][DATA_W-1:HALF] <= rd_lane[p][1] ? word[DATA_W-1:HALF] : '0;
                end
            end
        end
    end

endmodule

// File: rtl/twinport_ram.sv
module twinport_ram
    import twinport_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master_mode,
    input  logic              l_en,
    input  logic              l_wr,
    input  logic              l_out_en,
    input  logic              l_hi_sel,
    input  logic              l_lo_sel,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    input  logic              l_hold_n,
    output logic [DATA_W-1:0] l_rdata,
    output logic              l_rvalid,
    output logic              l_busy_n,
    input  logic              r_en,
    input  logic              r_wr,
    input  logic              r_out_en,
    input  logic              r_hi_sel,
    input  logic              r_lo_sel,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    input  logic              r_hold_n,
    output logic [DATA_W-1:0] r_rdata,
    output logic              r_rvalid,
    output logic              r_busy_n
);

    logic [PORTS-1:0]              en_v, wr_v, oe_v, hi_v, lo_v, hold_v;
    logic [PORTS-1:0][ADDR_W-1:0]  addr_v;
    logic [PORTS-1:0][DATA_W-1:0]  wdata_v, rdata_v;
    logic [PORTS-1:0]              lose, blocked, rd_req, rvalid_v;
    logic [PORTS-1:0][1:0]         wr_lane, rd_lane;

    assign en_v    = {r_en,     l_en};
    assign wr_v    = {r_wr,     l_wr};
    assign oe_v    = {r_out_en, l_out_en};
    assign hi_v    = {r_hi_sel, l_hi_sel};
    assign lo_v    = {r_lo_sel, l_lo_sel};
    assign hold_v  = {r_hold_n, l_hold_n};
    assign addr_v  = {r_addr,   l_addr};
    assign wdata_v = {r_wdata,  l_wdata};

    twinport_arbiter #(.ADDR_W(ADDR_W)) u_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en_v),
        .addr  (addr_v),
        .lose  (lose)
    );

    for (genvar p = 0; p < PORTS; p++) begin : g_port
        assign blocked[p] = master_mode ? lose[p] : !hold_v[p];

        twinport_gate u_gate (
            .en      (en_v[p]),
            .wr      (wr_v[p]),
            .out_en  (oe_v[p]),
            .hi_sel  (hi_v[p]),
            .lo_sel  (lo_v[p]),
            .blocked (blocked[p]),
            .wr_lane (wr_lane[p]),
            .rd_req  (rd_req[p]),
            .rd_lane (rd_lane[p])
        );
    end

    twinport_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (addr_v),
        .wdata   (wdata_v),
        .wr_lane (wr_lane),
        .rd_req  (rd_req),
        .rd_lane (rd_lane),
        .rdata   (rdata_v),
        .rvalid  (rvalid_v)
    );

    assign l_rdata  = rdata_v[LEFT];
    assign r_rdata  = rdata_v[RIGHT];
    assign l_rvalid = rvalid_v[LEFT];
    assign r_rvalid = rvalid_v[RIGHT];
    assign l_busy_n = !(master_mode && lose[LEFT]);
    assign r_busy_n = !(master_mode && lose[RIGHT]);

endmodule

// File: rtl/twinport_ram_chk.sv
module twinport_ram_chk #(
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              master_mode,
    input logic              l_en,
    input logic              l_wr,
    input logic [ADDR_W-1:0] l_addr,
    input logic              l_rvalid,
    input logic              l_busy_n,
    input logic              r_en,
    input logic              r_wr,
    input logic [ADDR_W-1:0] r_addr,
    input logic              r_rvalid,
    input logic              r_busy_n
);

    assert_one_loser_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(!l_busy_n && !r_busy_n));

    assert_left_busy_needs_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !l_busy_n |-> (master_mode && l_en && r_en && (l_addr == r_addr)));

    assert_right_busy_needs_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !r_busy_n |-> (master_mode && l_en && r_en && (l_addr == r_addr)));

    assert_slave_busy_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !master_mode |-> (l_busy_n && r_busy_n));

    assert_left_no_valid_after_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (l_en && l_wr) |=> !l_rvalid);

    assert_right_no_valid_after_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_en && r_wr) |=> !r_rvalid);

    assert_left_loses_late_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !l_busy_n |-> $past(r_en));

endmodule

bind twinport_ram twinport_ram_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .master_mode (master_mode),
    .l_en        (l_en),
    .l_wr        (l_wr),
    .l_addr      (l_addr),
    .l_rvalid    (l_rvalid),
    .l_busy_n    (l_busy_n),
    .r_en        (r_en),
    .r_wr        (r_wr),
    .r_addr      (r_addr),
    .r_rvalid    (r_rvalid),
    .r_busy_n    (r_busy_n)
);

// File: tb/twinport_ram_bench.sv
module twinport_ram_bench;

    localparam int AW = 4;
    localparam int DW = 18;
    localparam int H  = DW / 2;
    localparam int N  = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic master_mode = 1'b1;
    logic l_en = 0, l_wr = 0, l_out_en = 0, l_hi_sel = 0, l_lo_sel = 0, l_hold_n = 1;
    logic r_en = 0, r_wr = 0, r_out_en = 0, r_hi_sel = 0, r_lo_sel = 0, r_hold_n = 1;
    logic [AW-1:0] l_addr = '0, r_addr = '0;
    logic [DW-1:0] l_wdata = '0, r_wdata = '0;
    logic [DW-1:0] l_rdata, r_rdata;
    logic l_rvalid, r_rvalid, l_busy_n, r_busy_n;

    int checks = 0;
    int errors = 0;
    logic [DW-1:0] model [N];
    logic [DW-1:0] old;

    always #4 clk = ~clk;

    twinport_ram #(.ADDR_W(AW), .DATA_W(DW)) u_twinport_ram (
        .clk(clk), .rst_n(rst_n), .master_mode(master_mode),
        .l_en(l_en), .l_wr(l_wr), .l_out_en(l_out_en), .l_hi_sel(l_hi_sel),
        .l_lo_sel(l_lo_sel), .l_addr(l_addr), .l_wdata(l_wdata), .l_hold_n(l_hold_n),
        .l_rdata(l_rdata), .l_rvalid(l_rvalid), .l_busy_n(l_busy_n),
        .r_en(r_en), .r_wr(r_wr), .r_out_en(r_out_en), .r_hi_sel(r_hi_sel),
        .r_lo_sel(r_lo_sel), .r_addr(r_addr), .r_wdata(r_wdata), .r_hold_n(r_hold_n),
        .r_rdata(r_rdata), .r_rvalid(r_rvalid), .r_busy_n(r_busy_n)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] pat(input int a, input int s);
        return DW'((a * 7919 + s * 104729) ^ 18'h2A5A5);
    endfunction

    function automatic logic [DW-1:0] rdexp(input int a, input logic hi, input logic lo);
        return {hi ? model[a][DW-1:H] : {H{1'b0}}, lo ? model[a][H-1:0] : {H{1'b0}}};
    endfunction

    task automatic mwrite(input int a, input logic [DW-1:0] d, input logic hi, input logic lo);
        if (lo) model[a][H-1:0]  = d[H-1:0];
        if (hi) model[a][DW-1:H] = d[DW-1:H];
    endtask

    task automatic set_l(input logic en, input logic wr, input logic oe, input logic hi,
                         input logic lo, input int a, input logic [DW-1:0] d);
        l_en = en; l_wr = wr; l_out_en = oe; l_hi_sel = hi; l_lo_sel = lo;
        l_addr = AW'(a); l_wdata = d;
    endtask

    task automatic set_r(input logic en, input logic wr, input logic oe, input logic hi,
                         input logic lo, input int a, input logic [DW-1:0] d);
        r_en = en; r_wr = wr; r_out_en = oe; r_hi_sel = hi; r_lo_sel = lo;
        r_addr = AW'(a); r_wdata = d;
    endtask

    task automatic idle();
        set_l(0, 0, 0, 0, 0, 0, '0);
        set_r(0, 0, 0, 0, 0, 0, '0);
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [DW-1:0] d1, d2;
        // R10: reset state
        tick(); tick(); tick();
        chk("R10", "l_rvalid in reset", l_rvalid, 0);
        chk("R10", "r_rvalid in reset", r_rvalid, 0);
        chk("R10", "l_busy_n in reset", l_busy_n, 1);
        chk("R10", "r_busy_n in reset", r_busy_n, 1);
        rst_n = 1'b1;
        tick();
        chk("R10", "l_rvalid after reset", l_rvalid, 0);
        chk("R10", "r_busy_n after reset", r_busy_n, 1);

        // R1: concurrent writes and reads on distinct addresses
        for (int i = 0; i < N / 2; i++) begin
            set_l(1, 1, 0, 1, 1, i, pat(i, 1));
            set_r(1, 1, 0, 1, 1, i + N / 2, pat(i + N / 2, 1));
            #1;
            chk("R6", "l_busy_n distinct", l_busy_n, 1);
            chk("R6", "r_busy_n distinct", r_busy_n, 1);
            tick();
            chk("R3", "l_rvalid after write", l_rvalid, 0);
            mwrite(i, pat(i, 1), 1, 1);
            mwrite(i + N / 2, pat(i + N / 2, 1), 1, 1);
        end
        for (int i = 0; i < N / 2; i++) begin
            set_l(1, 0, 1, 1, 1, i + N / 2, '0);
            set_r(1, 0, 1, 1, 1, i, '0);
            tick();
            chk("R1", "l_rdata sweep", l_rdata, rdexp(i + N / 2, 1, 1));
            chk("R1", "r_rdata sweep", r_rdata, rdexp(i, 1, 1));
            chk("R3", "l_rvalid read", l_rvalid, 1);
            chk("R3", "r_rvalid read", r_rvalid, 1);
        end
        idle();

        // R2: single-lane writes and reads
        for (int a = 0; a < N; a++) begin
            logic odd;
            odd = a[0];
            set_l(1, 1, 0, odd, !odd, a, pat(a, 2));
            tick();
            mwrite(a, pat(a, 2), odd, !odd);
            set_l(1, 0, 1, 1, 0, a, '0);
            tick();
            chk("R2", "high lane read", l_rdata, rdexp(a, 1, 0));
            set_l(1, 0, 1, 0, 1, a, '0);
            tick();
            chk("R2", "low lane read", l_rdata, rdexp(a, 0, 1));
        end

        // R3: rvalid low for non-read cycles
        set_l(1, 0, 0, 1, 1, 2, '0); tick();
        chk("R3", "rvalid with output enable low", l_rvalid, 0);
        set_l(1, 0, 1, 0, 0, 2, '0); tick();
        chk("R3", "rvalid with no lane", l_rvalid, 0);
        set_l(0, 0, 1, 1, 1, 2, '0); tick();
        chk("R3", "rvalid when disabled", l_rvalid, 0);
        idle(); tick();

        // R4: simultaneous arrival, left wins
        d1 = pat(5, 7); d2 = pat(5, 8);
        set_l(1, 1, 0, 1, 1, 5, d1);
        set_r(1, 1, 0, 1, 1, 5, d2);
        #1;
        chk("R4", "r_busy_n tie", r_busy_n, 0);
        chk("R4", "l_busy_n tie", l_busy_n, 1);
        tick();
        mwrite(5, d1, 1, 1);
        idle(); tick();
        set_l(1, 0, 1, 1, 1, 5, '0); tick();
        chk("R7", "blocked right write left no trace", l_rdata, rdexp(5, 1, 1));
        idle(); tick();

        // R7: busy read returns old word
        d1 = pat(9, 9);
        set_l(1, 1, 0, 1, 1, 9, d1);
        set_r(1, 0, 1, 1, 1, 9, '0);
        #1;
        chk("R4", "r_busy_n read tie", r_busy_n, 0);
        old = rdexp(9, 1, 1);
        tick();
        chk("R7", "busy read old word", r_rdata, old);
        chk("R7", "busy read valid", r_rvalid, 1);
        mwrite(9, d1, 1, 1);
        idle(); tick();
        set_r(1, 0, 1, 1, 1, 9, '0); tick();
        chk("R7", "granted write landed", r_rdata, rdexp(9, 1, 1));
        idle(); tick();

        // R5/R6: settled right keeps the grant
        set_r(1, 0, 1, 1, 1, 6, '0);
        #1;
        chk("R6", "l_busy_n right alone", l_busy_n, 1);
        tick();
        set_l(1, 1, 0, 1, 1, 6, pat(6, 11));
        #1;
        chk("R5", "l_busy_n late arrival", l_busy_n, 0);
        chk("R5", "r_busy_n late arrival", r_busy_n, 1);
        tick();
        #1;
        chk("R5", "l_busy_n persists", l_busy_n, 0);
        tick();
        set_l(1, 0, 1, 1, 1, 6, '0);
        set_r(1, 0, 1, 1, 1, 7, '0);
        #1;
        chk("R6", "l_busy_n released", l_busy_n, 1);
        chk("R6", "r_busy_n released", r_busy_n, 1);
        tick();
        chk("R7", "blocked left write", l_rdata, rdexp(6, 1, 1));
        set_r(0, 0, 0, 0, 0, 0, '0);
        set_l(1, 0, 1, 1, 1, 7, '0);
        #1;
        chk("R6", "busy high when other disabled", l_busy_n, 1);
        idle(); tick();

        // R8/R9: slave mode
        master_mode = 1'b0;
        d1 = pat(3, 12); d2 = pat(3, 13);
        set_l(1, 1, 0, 1, 1, 3, d1);
        set_r(1, 1, 0, 1, 1, 3, d2);
        #1;
        chk("R8", "slave l_busy_n", l_busy_n, 1);
        chk("R8", "slave r_busy_n", r_busy_n, 1);
        tick();
        mwrite(3, d1, 1, 1); mwrite(3, d2, 1, 1);
        idle();
        set_l(1, 0, 1, 1, 1, 3, '0); tick();
        chk("R9", "right wins lane tie", l_rdata, rdexp(3, 1, 1));
        d1 = pat(4, 14); d2 = pat(4, 15);
        set_l(1, 1, 0, 0, 1, 4, d1);
        set_r(1, 1, 0, 1, 0, 4, d2);
        tick();
        mwrite(4, d1, 0, 1); mwrite(4, d2, 1, 0);
        idle();
        set_l(1, 0, 1, 1, 1, 4, '0); tick();
        chk("R9", "split lanes both land", l_rdata, rdexp(4, 1, 1));
        l_hold_n = 1'b0;
        set_l(1, 1, 0, 1, 1, 2, pat(2, 16)); tick();
        set_l(1, 0, 1, 1, 1, 2, '0); tick();
        chk("R8", "hold blocks left write", l_rdata, rdexp(2, 1, 1));
        chk("R8", "hold leaves read valid", l_rvalid, 1);
        idle();
        r_hold_n = 1'b0;
        set_r(1, 1, 0, 1, 1, 12, pat(12, 17)); tick();
        set_r(1, 0, 1, 1, 1, 12, '0); tick();
        chk("R8", "hold blocks right write", r_rdata, rdexp(12, 1, 1));
        idle(); tick();

        // R8: hold ignored in master mode
        master_mode = 1'b1;
        d1 = pat(1, 18);
        set_l(1, 1, 0, 1, 1, 1, d1); tick();
        mwrite(1, d1, 1, 1);
        set_l(1, 0, 1, 1, 1, 1, '0); tick();
        chk("R8", "hold ignored in master mode", l_rdata, rdexp(1, 1, 1));
        idle(); tick();

        finish_run();
    end

endmodule